// File: doc/BRIEF.md
# Platform Status and Control Register Block

This block is a small 32-bit register file on a simple memory-mapped request bus. Board-level software uses it to learn the build configuration, the memory setup and the timer reference clock, and to ask for a full system reset. Most registers are read-only. Their values are either constants or fields packed on the fly from two live inputs: the timer reference frequency in MHz and the installed memory size in GiB.

A request is a single cycle with `req_valid` high. Only word (4-byte) requests are honoured, and only the low 16 address bits select a register. Reads return data through a registered output one cycle later, marked by `rd_valid`. A word write to the soft-reset register with bit 4 set produces a one-cycle `rst_req` pulse for an external reset sequencer. Writes to the status registers, and to any unmapped offset, are dropped without effect.

Top module: `plat_ctl_regs`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rd_valid`, `rst_req` and `rd_data` are all zero.
- R2: A read request (`req_valid`=1, `req_write`=0) in cycle t sets `rd_valid` high for exactly cycle t+1, with the result on `rd_data`. `rd_data` then holds that value until the next read completes.
- R3: `req_size` encodes the access width: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. Only code 2 is honoured. Any other read returns zero, and any other write has no effect, including no reset pulse.
- R4: The register is selected by `req_addr[15:0]` alone, and the upper address bits are ignored. Any offset not listed in R6 to R9 reads as zero. This covers 0x00, 0x04, 0x08, 0x10, 0x18 and misaligned offsets.
- R5: A word write to offset 0x10 with `req_wdata[4]`=1 drives `rst_req` high for exactly the following cycle. With bit 4 clear, no pulse is produced, whatever the other bits hold.
- R6: A word read of offset 0x14 returns 0x00000005 (locked bit 0, calibrated bit 2).
- R7: A word read of offset 0x30 returns `{8'h01, 8'h01, tmr_mhz, 8'h01}`: divider-1 in [31:24], multiplier in [23:16], frequency in [15:8], divider-0 in [7:0].
- R8: A word read of offset 0x34 returns 0x0000000E. This means three port-enable bits 1 to 3 are set and bit 0, the coherence unit, is clear.
- R9: A word read of offset 0x38 returns `{16'h0000, 12'hFFF, mem_gib}`, with the size in [3:0] and an all-ones speed field in [15:4].
- R10: Writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34, 0x38 and to unmapped offsets change no later read value and produce no reset pulse.
- R11: A read reflects the `tmr_mhz` and `mem_gib` values present in its request cycle. A change in the following cycle does not alter the returned word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code (2 = 4 bytes) |
| req_addr | input | 32 | Byte address; low 16 bits decoded |
| req_wdata | input | 32 | Write data |
| tmr_mhz | input | 8 | Timer reference frequency in MHz |
| mem_gib | input | 4 | Installed memory size in GiB |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the size filter and exercises every offset with sub-word and double-word codes. A block that checked only the address would return live status or fire a reset on a byte write. Writes to the reset offset with bit 4 clear, followed by all other bits set, show whether the design wrongly tests the whole word. Addresses with random upper halves catch decoders that compare too many bits. Inputs are changed right after each request to expose a read path that is not sampled at the request edge. Read-only offsets are written and then read back, which shows up any stray storage.

// File: rtl/plat_ctl_pkg.sv
package plat_ctl_pkg;

   localparam int unsigned WORD_SIZE_CODE = 2;

   localparam logic [15:0] OFS_SOFTRST  = 16'h0010;
   localparam logic [15:0] OFS_MEMSTAT  = 16'h0014;
   localparam logic [15:0] OFS_CLKDIV   = 16'h0030;
   localparam logic [15:0] OFS_BUILD    = 16'h0034;
   localparam logic [15:0] OFS_MEMCFG   = 16'h0038;

   localparam logic [31:0] MEMSTAT_WORD = 32'h0000_0005;
   localparam logic [31:0] BUILD_WORD   = 32'h0000_000E;

   typedef enum logic [2:0] {
      RS_ZERO,
      RS_MEMSTAT,
      RS_CLKDIV,
      RS_BUILD,
      RS_MEMCFG
   } rsel_e;

   typedef struct packed {
      logic  rd_fire;
      logic  rst_hit;
      rsel_e sel;
   } dec_t;

endpackage

// File: rtl/plat_ctl_decode.sv
module plat_ctl_decode
   import plat_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 16,
   parameter int unsigned SIZE_W = 2
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [ADDR_W-1:0] req_addr,
   output dec_t              dec
);
   localparam int unsigned PAD_W = 16 - OFFS_W;

   if (OFFS_W > 16 || OFFS_W < 6) begin : g_bad_offs
      $error("plat_ctl_decode: OFFS_W must be 6..16");
   end
   if (ADDR_W < OFFS_W) begin : g_bad_addr
      $error("plat_ctl_decode: ADDR_W below OFFS_W");
   end

   logic [15:0] offs;
   logic        word_ok;

   if (PAD_W == 0) begin : g_full
      assign offs = req_addr[15:0];
   end else begin : g_pad
      assign offs = {{PAD_W{1'b0}}, req_addr[OFFS_W-1:0]};
   end

   assign word_ok = (req_size == SIZE_W'(WORD_SIZE_CODE));

   always_comb begin
      dec.rd_fire = req_valid && !req_write;
      dec.rst_hit = req_valid && req_write && word_ok && (offs == OFS_SOFTRST);
      dec.sel     = RS_ZERO;
      if (word_ok) begin
         unique case (offs)
            OFS_MEMSTAT: dec.sel = RS_MEMSTAT;
            OFS_CLKDIV:  dec.sel = RS_CLKDIV;
            OFS_BUILD:   dec.sel = RS_BUILD;
            OFS_MEMCFG:  dec.sel = RS_MEMCFG;
            default:     dec.sel = RS_ZERO;
         endcase
      end
   end
endmodule

// File: rtl/plat_ctl_rdmux.sv
module plat_ctl_rdmux
   import plat_ctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FREQ_W = 8,
   parameter int unsigned GIB_W  = 4
) (
   input  rsel_e             sel,
   input  logic [FREQ_W-1:0] tmr_mhz,
   input  logic [GIB_W-1:0]  mem_gib,
   output logic [DATA_W-1:0] word
);
   if (DATA_W != 32) begin : g_bad_data
      $error("plat_ctl_rdmux: DATA_W must be 32");
   end
   if (FREQ_W > 8 || FREQ_W == 0) begin : g_bad_freq
      $error("plat_ctl_rdmux: FREQ_W must be 1..8");
   end
   if (GIB_W > 4 || GIB_W == 0) begin : g_bad_gib
      $error("plat_ctl_rdmux: GIB_W must be 1..4");
   end

   logic [7:0]  mhz_f;
   logic [3:0]  gib_f;
   logic [31:0] clk_word;
   logic [31:0] cfg_word;

   assign mhz_f    = 8'(tmr_mhz);
   assign gib_f    = 4'(mem_gib);
   assign clk_word = {8'h01, 8'h01, mhz_f, 8'h01};
   assign cfg_word = {16'h0000, 12'hFFF, gib_f};

   always_comb begin
      unique case (sel)
         RS_MEMSTAT: word = MEMSTAT_WORD;
         RS_CLKDIV:  word = clk_word;
         RS_BUILD:   word = BUILD_WORD;
         RS_MEMCFG:  word = cfg_word;
         default:    word = '0;
      endcase
   end
endmodule

// File: rtl/plat_ctl_rstgen.sv
module plat_ctl_rstgen #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned RST_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              pulse
);
   if (RST_BIT >= DATA_W) begin : g_bad_bit
      $error("plat_ctl_rstgen: RST_BIT outside data word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= hit && wdata[RST_BIT];
   end
endmodule

// File: rtl/plat_ctl_regs.sv
module plat_ctl_regs
   import plat_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned OFFS_W  = 16,
   parameter int unsigned SIZE_W  = 2,
   parameter int unsigned FREQ_W  = 8,
   parameter int unsigned GIB_W   = 4,
   parameter int unsigned RST_BIT = 4,
   parameter bit          RD_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [FREQ_W-1:0] tmr_mhz,
   input  logic [GIB_W-1:0]  mem_gib,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req
);
   dec_t              dec;
   logic [DATA_W-1:0] word;

   plat_ctl_decode #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SIZE_W(SIZE_W)
   ) u_dec (
      .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .dec(dec)
   );

   plat_ctl_rdmux #(
      .DATA_W(DATA_W), .FREQ_W(FREQ_W), .GIB_W(GIB_W)
   ) u_mux (
      .sel(dec.sel), .tmr_mhz(tmr_mhz), .mem_gib(mem_gib), .word(word)
   );

   plat_ctl_rstgen #(
      .DATA_W(DATA_W), .RST_BIT(RST_BIT)
   ) u_rst (
      .clk(clk), .rst_n(rst_n), .hit(dec.rst_hit),
      .wdata(req_wdata), .pulse(rst_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= dec.rd_fire;
   end

   if (RD_HOLD) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)           rd_data <= '0;
         else if (dec.rd_fire) rd_data <= word;
      end
   end else begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n || !dec.rd_fire) rd_data <= '0;
         else                        rd_data <= word;
      end
   end
endmodule

// File: rtl/plat_ctl_regs_chk.sv
module plat_ctl_regs_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SIZE_W  = 2,
   parameter bit          RD_HOLD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [SIZE_W-1:0] req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rst_req
);
   logic rd_req, word_sz;
   assign rd_req  = req_valid && !req_write;
   assign word_sz = (req_size == SIZE_W'(2));

   p_rd_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   p_rd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));
   if (RD_HOLD) begin : g_hold_chk
      p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_req |=> $stable(rd_data));
   end
   p_badsize_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !word_sz) |=> (rd_data == '0));
   p_badsize_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !word_sz) |=> !rst_req);
   p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(req_valid && req_write && word_sz
                        && req_addr[15:0] == 16'h0010 && req_wdata[4]));
   p_memstat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && word_sz && req_addr[15:0] == 16'h0014) |=> (rd_data == 32'h5));
   p_build_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && word_sz && req_addr[15:0] == 16'h0034) |=> (rd_data == 32'hE));
endmodule

bind plat_ctl_regs plat_ctl_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .RD_HOLD(RD_HOLD)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
   .rd_valid(rd_valid), .rd_data(rd_data), .rst_req(rst_req)
);

// File: tb/plat_ctl_regs_tb_top.sv
module plat_ctl_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [7:0]  tmr_mhz = 8'd0;
   logic [3:0]  mem_gib = 4'd0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        rst_req;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   plat_ctl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .tmr_mhz(tmr_mhz), .mem_gib(mem_gib), .rd_valid(rd_valid),
      .rd_data(rd_data), .rst_req(rst_req)
   );

   function automatic logic [31:0] exp_read(logic [31:0] a, logic [1:0] sz,
                                            logic [7:0] mhz, logic [3:0] gib);
      if (sz != 2'd2) return 32'h0;
      case (a[15:0])
         16'h0014: return 32'h0000_0005;
         16'h0030: return {8'h01, 8'h01, mhz, 8'h01};
         16'h0034: return 32'h0000_000E;
         16'h0038: return {16'h0, 12'hFFF, gib};
         default:  return 32'h0;
      endcase
   endfunction

   function automatic logic exp_rst(logic [31:0] a, logic [1:0] sz, logic [31:0] d);
      return (sz == 2'd2) && (a[15:0] == 16'h0010) && d[4];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one request cycle; returns at the negedge after the capturing edge
   task automatic issue(logic wr, logic [31:0] a, logic [1:0] sz, logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [31:0] a, logic [1:0] sz);
      logic [31:0] e;
      e = exp_read(a, sz, tmr_mhz, mem_gib);
      issue(1'b0, a, sz, 32'h0);
      check(req, {31'h0, rd_valid}, 32'h1);
      check(req, rd_data, e);
   endtask

   task automatic wr_chk(string req, logic [31:0] a, logic [1:0] sz, logic [31:0] d);
      issue(1'b1, a, sz, d);
      check(req, {31'h0, rst_req}, {31'h0, exp_rst(a, sz, d)});
      @(negedge clk);
      check(req, {31'h0, rst_req}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] pool [14];
      logic [31:0] keep;
      void'($urandom(32'h5EED_0042));
      pool = '{16'h0000, 16'h0004, 16'h0008, 16'h000C, 16'h0010, 16'h0014,
               16'h0018, 16'h001C, 16'h0030, 16'h0034, 16'h0038, 16'h003C,
               16'h0015, 16'h0032};
      tmr_mhz = 8'd100; mem_gib = 4'd2;
      repeat (3) @(negedge clk);
      check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
      check("R1 rst_req", {31'h0, rst_req}, 32'h0);
      check("R1 rd_data", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {30'h0, rd_valid, rst_req}, 32'h0);

      rd_chk("R6 memstat", 32'h0000_0014, 2'd2);
      rd_chk("R7 clkdiv", 32'h0000_0030, 2'd2);
      rd_chk("R8 build", 32'h0000_0034, 2'd2);
      rd_chk("R9 memcfg", 32'h0000_0038, 2'd2);
      mem_gib = 4'hF; tmr_mhz = 8'hFF;
      rd_chk("R9 memcfg max", 32'h0000_0038, 2'd2);
      rd_chk("R7 clkdiv max", 32'h0000_0030, 2'd2);
      rd_chk("R4 upper bits ignored", 32'hDEAD_0014, 2'd2);
      rd_chk("R4 offset 0x00", 32'h0000_0000, 2'd2);
      rd_chk("R4 offset 0x10", 32'h0000_0010, 2'd2);
      rd_chk("R4 misaligned", 32'h0000_0035, 2'd2);
      rd_chk("R3 byte read", 32'h0000_0014, 2'd0);
      rd_chk("R3 dword read", 32'h0000_0034, 2'd3);

      // R2: data holds, valid drops
      rd_chk("R2 setup", 32'h0000_0034, 2'd2);
      repeat (2) @(negedge clk);
      check("R2 valid drops", {31'h0, rd_valid}, 32'h0);
      check("R2 data holds", rd_data, 32'h0000_000E);

      // R11: input change right after request
      tmr_mhz = 8'd50;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h30; req_size = 2'd2;
      @(negedge clk);
      req_valid = 1'b0; tmr_mhz = 8'd77;
      check("R11 sampled at request", rd_data, 32'h0101_3201);

      // R5 reset pulse
      wr_chk("R5 bit4 set", 32'h0000_0010, 2'd2, 32'h0000_0010);
      wr_chk("R5 bit4 clear", 32'h0000_0010, 2'd2, 32'hFFFF_FFEF);
      wr_chk("R5 upper addr", 32'hABCD_0010, 2'd2, 32'h0000_0010);
      wr_chk("R3 halfword reset write", 32'h0000_0010, 2'd1, 32'hFFFF_FFFF);
      wr_chk("R3 byte reset write", 32'h0000_0010, 2'd0, 32'h0000_0010);

      // R10 read-only offsets ignore writes
      for (int i = 0; i < 12; i++) begin
         wr_chk("R10 ro write", {16'h0, pool[i] == 16'h0010 ? 16'h0018 : pool[i]},
                2'd2, 32'hFFFF_FFFF);
      end
      rd_chk("R10 memstat after write", 32'h14, 2'd2);
      rd_chk("R10 build after write", 32'h34, 2'd2);
      rd_chk("R10 zero reg after write", 32'h04, 2'd2);

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         a  = {16'($urandom), pool[$urandom % 14]};
         sz = ($urandom % 4 == 0) ? 2'($urandom) : 2'd2;
         tmr_mhz = 8'($urandom); mem_gib = 4'($urandom);
         if ($urandom % 3 == 0) wr_chk("R5/R10 random write", a, sz, $urandom);
         else                   rd_chk("R4/R7/R9 random read", a, sz);
      end
      keep = rd_data;
      repeat (3) @(negedge clk);
      check("R2 final hold", rd_data, keep);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule